// File: doc/BRIEF.md
# Registered 12-to-24 Bus Exchanger

This block moves data between a narrow A side of `HALF_W` bits and a wide B side of two `HALF_W`-bit halves, called the low half and the high half. Going from A to B, each half has its own capture register and its own active-low capture enable. Two A words offered on successive clocks can therefore be stacked into one `2*HALF_W`-bit word on the B bus. Going from B to A, a registered half-select picks either the low or the high B input. A single A register loads the picked half on every clock edge.

Every control input is sampled into a flop before it acts. This covers both capture enables, the half-select and the three active-low output enables. The data inputs are staged in the same edge, so all data and its control pass through one input register stage. An enable or word presented at edge k changes the data register at edge k+1 and is visible on the outputs after that edge. An output enable presented at edge k is visible right after edge k. Each output enable is modelled as a data bus plus a valid flag rather than a tri-state driver. Data registers have no reset. A synchronous active-high reset returns the control register to idle: no capture, and no port valid. Outputs are undefined before the first clock edge.

Top module: `bus_exchanger`

## Requirements
- R1: When `cap_lo_n` is 0 at edge k, the `a_in` value sampled at edge k appears on `b_out[HALF_W-1:0]` after edge k+1.
- R2: When `cap_hi_n` is 0 at edge k, the `a_in` value sampled at edge k appears on `b_out[2*HALF_W-1:HALF_W]` after edge k+1.
- R3: A half whose capture enable was 1 at edge k keeps its contents through edge k+1, whatever `a_in` is.
- R4: With both capture enables 0 at the same edge, the same A word is written into both halves.
- R5: A word captured into the low half at edge k and a second word captured into the high half at edge k+1 are shown together on `b_out` after edge k+2, with the first word in the low half.
- R6: After edge k+1, `a_out` equals the `b_lo_in` value sampled at edge k when `sel_hi` was 0 at edge k, and the `b_hi_in` value when `sel_hi` was 1. The A register reloads on every edge, with no hold.
- R7: After edge k, `a_vld`, `b_lo_vld` and `b_hi_vld` are each the inverse of `oe_a_n`, `oe_lo_n` and `oe_hi_n` sampled at edge k. Each flag depends only on its own enable.
- R8: An edge with `rst` at 1 clears all three valid flags. The enables sampled at that edge cause no capture at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the control register |
| a_in | input | HALF_W | A-side word headed for the B halves |
| b_lo_in | input | HALF_W | Low B half headed for A |
| b_hi_in | input | HALF_W | High B half headed for A |
| cap_lo_n | input | 1 | Active-low capture enable, low half |
| cap_hi_n | input | 1 | Active-low capture enable, high half |
| sel_hi | input | 1 | Half-select for A: 0 low half, 1 high half |
| oe_a_n | input | 1 | Active-low output enable, A port |
| oe_lo_n | input | 1 | Active-low output enable, low B half |
| oe_hi_n | input | 1 | Active-low output enable, high B half |
| a_out | output | HALF_W | A-side data from the A register |
| a_vld | output | 1 | A port driven |
| b_out | output | 2*HALF_W | Both B halves, low half in the low bits |
| b_lo_vld | output | 1 | Low B half driven |
| b_hi_vld | output | 1 | High B half driven |

## Verification
A capture-enable register stuck at the wrong level or wired to the wrong half has a visible effect. It shows up as a wrong or unchanged half on `b_out` two edges after the word was offered. A swapped half-select shows the wrong B half on `a_out` after the same two edges. A missing reload on the A side leaves `a_out` one word behind. A wrong output-enable register flips a valid flag right after the edge that sampled it. A reset that fails to idle the control register either leaves a flag set after the reset edge or overwrites a half one edge later.

// File: rtl/bx_pkg.sv
package bx_pkg;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_sel_e;

  typedef struct packed {
    logic      cap_lo_n;
    logic      cap_hi_n;
    half_sel_e sel;
    logic      oe_a_n;
    logic      oe_lo_n;
    logic      oe_hi_n;
  } bx_ctrl_t;

  localparam bx_ctrl_t BX_CTRL_IDLE = '{
    cap_lo_n: 1'b1,
    cap_hi_n: 1'b1,
    sel:      HALF_LO,
    oe_a_n:   1'b1,
    oe_lo_n:  1'b1,
    oe_hi_n:  1'b1
  };

endpackage

// File: rtl/bx_ctrl_reg.sv
module bx_ctrl_reg
  import bx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  bx_ctrl_t d,
  output bx_ctrl_t q
);

  always_ff @(posedge clk) begin
    if (rst) q <= BX_CTRL_IDLE;
    else     q <= d;
  end

endmodule

// File: rtl/bx_half_reg.sv
module bx_half_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         cap_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  // data storage: no reset, loads only while its registered enable is low
  always_ff @(posedge clk) begin
    if (!cap_n) q <= d;
  end

endmodule

// File: rtl/bx_a_path.sv
module bx_a_path
  import bx_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  half_sel_e    sel,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] q
);

  logic [W-1:0] pick;

  always_comb begin
    pick = (sel == HALF_HI) ? hi : lo;
  end

  // single B-to-A storage register, reloaded every edge
  always_ff @(posedge clk) begin
    q <= pick;
  end

endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger
  import bx_pkg::*;
#(
  parameter int HALF_W = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [HALF_W-1:0]     a_in,
  input  logic [HALF_W-1:0]     b_lo_in,
  input  logic [HALF_W-1:0]     b_hi_in,
  input  logic                  cap_lo_n,
  input  logic                  cap_hi_n,
  input  logic                  sel_hi,
  input  logic                  oe_a_n,
  input  logic                  oe_lo_n,
  input  logic                  oe_hi_n,
  output logic [HALF_W-1:0]     a_out,
  output logic                  a_vld,
  output logic [2*HALF_W-1:0]   b_out,
  output logic                  b_lo_vld,
  output logic                  b_hi_vld
);

  localparam int NHALF  = 2;
  localparam int FULL_W = NHALF * HALF_W;

  bx_ctrl_t ctrl_d;
  bx_ctrl_t ctrl_q;

  always_comb begin
    ctrl_d.cap_lo_n = cap_lo_n;
    ctrl_d.cap_hi_n = cap_hi_n;
    ctrl_d.sel      = half_sel_e'(sel_hi);
    ctrl_d.oe_a_n   = oe_a_n;
    ctrl_d.oe_lo_n  = oe_lo_n;
    ctrl_d.oe_hi_n  = oe_hi_n;
  end

  bx_ctrl_reg u_ctrl (
    .clk (clk),
    .rst (rst),
    .d   (ctrl_d),
    .q   (ctrl_q)
  );

  // input data staging, aligned with the control register
  logic [HALF_W-1:0] a_stg;
  logic [HALF_W-1:0] b_stg [NHALF];

  always_ff @(posedge clk) begin
    a_stg    <= a_in;
    b_stg[0] <= b_lo_in;
    b_stg[1] <= b_hi_in;
  end

  // A-to-B: one capture register per half
  logic [NHALF-1:0]  cap_n_q;
  logic [HALF_W-1:0] half_q [NHALF];
  logic [FULL_W-1:0] b_word;

  assign cap_n_q = {ctrl_q.cap_hi_n, ctrl_q.cap_lo_n};

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    bx_half_reg #(.W(HALF_W)) u_half (
      .clk   (clk),
      .cap_n (cap_n_q[h]),
      .d     (a_stg),
      .q     (half_q[h])
    );
    assign b_word[h*HALF_W +: HALF_W] = half_q[h];
  end

  // B-to-A: select then store
  bx_a_path #(.W(HALF_W)) u_apath (
    .clk (clk),
    .sel (ctrl_q.sel),
    .lo  (b_stg[0]),
    .hi  (b_stg[1]),
    .q   (a_out)
  );

  assign b_out    = b_word;
  assign a_vld    = !ctrl_q.oe_a_n;
  assign b_lo_vld = !ctrl_q.oe_lo_n;
  assign b_hi_vld = !ctrl_q.oe_hi_n;

endmodule

// File: rtl/bx_chk.sv
module bx_chk #(
  parameter int HALF_W = 12
) (
  input logic                clk,
  input logic                rst,
  input logic [HALF_W-1:0]   a_in,
  input logic [HALF_W-1:0]   b_lo_in,
  input logic [HALF_W-1:0]   b_hi_in,
  input logic                cap_lo_n,
  input logic                cap_hi_n,
  input logic                sel_hi,
  input logic                oe_a_n,
  input logic                oe_lo_n,
  input logic                oe_hi_n,
  input logic [HALF_W-1:0]   a_out,
  input logic                a_vld,
  input logic [2*HALF_W-1:0] b_out,
  input logic                b_lo_vld,
  input logic                b_hi_vld
);

  // edges since reset, saturating
  logic [1:0] age;
  logic       rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst)               age <= 2'd0;
    else if (age != 2'd3)  age <= age + 2'd1;
  end

  // R7
  a_vld_chk: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0) |-> (a_vld == !$past(oe_a_n)));
  // R7
  lo_vld_chk: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0) |-> (b_lo_vld == !$past(oe_lo_n)));
  // R7
  hi_vld_chk: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0) |-> (b_hi_vld == !$past(oe_hi_n)));

  // R1
  lo_load_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && !$past(cap_lo_n, 2)) |-> (b_out[HALF_W-1:0] == $past(a_in, 2)));
  // R2
  hi_load_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && !$past(cap_hi_n, 2)) |-> (b_out[2*HALF_W-1:HALF_W] == $past(a_in, 2)));

  // R3
  lo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(cap_lo_n, 2)) |-> $stable(b_out[HALF_W-1:0]));
  // R3
  hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(cap_hi_n, 2)) |-> $stable(b_out[2*HALF_W-1:HALF_W]));

  // R6
  a_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |->
      (a_out == ($past(sel_hi, 2) ? $past(b_hi_in, 2) : $past(b_lo_in, 2))));

  // R8
  always @(negedge clk) begin
    if (rst_d === 1'b1) begin
      rst_idle_chk: assert (!a_vld && !b_lo_vld && !b_hi_vld);
    end
  end

endmodule

bind bus_exchanger bx_chk #(.HALF_W(HALF_W)) u_bx_chk (
  .clk      (clk),
  .rst      (rst),
  .a_in     (a_in),
  .b_lo_in  (b_lo_in),
  .b_hi_in  (b_hi_in),
  .cap_lo_n (cap_lo_n),
  .cap_hi_n (cap_hi_n),
  .sel_hi   (sel_hi),
  .oe_a_n   (oe_a_n),
  .oe_lo_n  (oe_lo_n),
  .oe_hi_n  (oe_hi_n),
  .a_out    (a_out),
  .a_vld    (a_vld),
  .b_out    (b_out),
  .b_lo_vld (b_lo_vld),
  .b_hi_vld (b_hi_vld)
);

// File: tb/test_bus_exchanger.sv
`timescale 1ns/1ps
module test_bus_exchanger;

  localparam int HW = 12;

  logic          clk = 1'b0;
  logic          rst;
  logic [HW-1:0] a_in, b_lo_in, b_hi_in;
  logic          cap_lo_n, cap_hi_n, sel_hi;
  logic          oe_a_n, oe_lo_n, oe_hi_n;
  logic [HW-1:0] a_out;
  logic          a_vld, b_lo_vld, b_hi_vld;
  logic [2*HW-1:0] b_out;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  bus_exchanger #(.HALF_W(HW)) i_bus_exchanger (
    .clk(clk), .rst(rst), .a_in(a_in), .b_lo_in(b_lo_in), .b_hi_in(b_hi_in),
    .cap_lo_n(cap_lo_n), .cap_hi_n(cap_hi_n), .sel_hi(sel_hi),
    .oe_a_n(oe_a_n), .oe_lo_n(oe_lo_n), .oe_hi_n(oe_hi_n),
    .a_out(a_out), .a_vld(a_vld), .b_out(b_out),
    .b_lo_vld(b_lo_vld), .b_hi_vld(b_hi_vld)
  );

  typedef struct packed {
    logic [11:0] a;
    logic        clo_n;
    logic        chi_n;
    logic [11:0] blo;
    logic [11:0] bhi;
    logic        sel;
    logic [2:0]  oe_n;   // {a, lo, hi}
    logic [23:0] exp_b;
    logic [11:0] exp_a;
    logic [2:0]  exp_v;  // {a, lo, hi}
  } vec_t;

  localparam int NV = 6;
  localparam vec_t TBL [NV] = '{
    '{12'h111, 1'b0, 1'b0, 12'h0AA, 12'h0BB, 1'b0, 3'b000, 24'h111111, 12'h0AA, 3'b111}, // R4
    '{12'hABC, 1'b0, 1'b1, 12'h0AA, 12'h0BB, 1'b1, 3'b100, 24'h111ABC, 12'h0BB, 3'b011}, // R1
    '{12'hDEF, 1'b1, 1'b0, 12'h123, 12'h456, 1'b0, 3'b010, 24'hDEFABC, 12'h123, 3'b101}, // R2
    '{12'hFFF, 1'b1, 1'b1, 12'h123, 12'h456, 1'b1, 3'b111, 24'hDEFABC, 12'h456, 3'b000}, // R3
    '{12'h000, 1'b0, 1'b1, 12'h000, 12'hFFF, 1'b1, 3'b001, 24'hDEF000, 12'hFFF, 3'b110}, // R1
    '{12'h5A5, 1'b1, 1'b0, 12'hA5A, 12'hFFF, 1'b0, 3'b000, 24'h5A5000, 12'hA5A, 3'b111}  // R2
  };

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #80000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; a_in = '0; b_lo_in = '0; b_hi_in = '0;
    cap_lo_n = 1'b0; cap_hi_n = 1'b0; sel_hi = 1'b0;
    oe_a_n = 1'b0; oe_lo_n = 1'b0; oe_hi_n = 1'b0;
    @(negedge clk);
    step();
    step();
    // R8: flags idle while reset is applied
    check("R8 reset valid flags", {21'd0, a_vld, b_lo_vld, b_hi_vld}, 24'd0);
    rst = 1'b0; cap_lo_n = 1'b1; cap_hi_n = 1'b1;

    // table walk: R1 R2 R3 R4 on b_out, R6 on a_out, R7 on flags
    for (int i = 0; i < NV; i++) begin
      a_in = TBL[i].a; cap_lo_n = TBL[i].clo_n; cap_hi_n = TBL[i].chi_n;
      b_lo_in = TBL[i].blo; b_hi_in = TBL[i].bhi; sel_hi = TBL[i].sel;
      {oe_a_n, oe_lo_n, oe_hi_n} = TBL[i].oe_n;
      step();
      cap_lo_n = 1'b1; cap_hi_n = 1'b1;
      step();
      check($sformatf("table(R1,R2,R3,R4) row %0d b_out", i), b_out, TBL[i].exp_b);
      check($sformatf("R6 row %0d a_out", i), {12'd0, a_out}, {12'd0, TBL[i].exp_a});
      check($sformatf("R7 row %0d valid flags", i),
            {21'd0, a_vld, b_lo_vld, b_hi_vld}, {21'd0, TBL[i].exp_v});
    end

    // R5: two successive words packed into one wide word
    a_in = 12'h321; cap_lo_n = 1'b0; cap_hi_n = 1'b1;
    step();
    a_in = 12'h654; cap_lo_n = 1'b1; cap_hi_n = 1'b0;
    step();
    check("R5 first word in low half", b_out, 24'h5A5321);
    cap_lo_n = 1'b1; cap_hi_n = 1'b1; a_in = 12'hBAD;
    step();
    check("R5 packed word", b_out, 24'h654321);

    // R6: A register reloads on every edge
    sel_hi = 1'b0; b_lo_in = 12'h010;
    step();
    b_lo_in = 12'h020;
    step();
    check("R6 reload first", {12'd0, a_out}, 24'h000010);
    step();
    check("R6 reload second", {12'd0, a_out}, 24'h000020);

    // R8: reset blocks the capture enables sampled with it
    a_in = 12'hEEE; cap_lo_n = 1'b0; cap_hi_n = 1'b0;
    oe_a_n = 1'b0; oe_lo_n = 1'b0; oe_hi_n = 1'b0; rst = 1'b1;
    step();
    check("R8 flags cleared by reset", {21'd0, a_vld, b_lo_vld, b_hi_vld}, 24'd0);
    rst = 1'b0; cap_lo_n = 1'b1; cap_hi_n = 1'b1;
    oe_a_n = 1'b1; oe_lo_n = 1'b1; oe_hi_n = 1'b1;
    step();
    step();
    check("R8 no capture after reset", b_out, 24'h654321);
    check("R8 flags stay idle", {21'd0, a_vld, b_lo_vld, b_hi_vld}, 24'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule